// File: doc/BRIEF.md
# Four-Port Shared Calculator

The block is an arithmetic service shared by four requestor ports. Each port drives its own command and data inputs and receives its own status code and result. Four operations are offered: unsigned add, unsigned subtract, logical shift left and logical shift right. A request spans two cycles. The first operand travels with the command, and the second operand arrives on the same data input one cycle later.

Accepted requests wait in their port until an arbiter grants them to one of two execution pipes. One pipe handles add and subtract, the other handles both shifts. The two pipes run concurrently, but each pipe holds only one operation at a time. Grants go to the request that has waited longest. When several requests have waited equally long, a rotating pointer decides, so that no port index is favoured. The outcome returns to the issuing port as a one-cycle status code, with the result on the data output in the same cycle.

Top module: `quad_port_calc`

## Requirements
- R1: Command codes are 1 = add, 2 = subtract, 5 = shift left and 6 = shift right, with 0 meaning idle. Operand A is sampled with the command and operand B on the next edge. A shift moves A by the amount in B[4:0] and ignores B[31:5]. A successful operation returns status 1 with the 32-bit result.
- R2: A nonzero status is driven for exactly one cycle, and the result is valid in that same cycle. Whenever the status is 0, the data output is zero. Status 3 is reserved and is never produced.
- R3: An add whose unsigned sum carries out of bit 31, or a subtract whose operand B is greater than operand A, returns status 2 with data zero.
- R4: Any nonzero command other than 1, 2, 5 or 6 returns status 2 with data zero. It is reported in the cycle right after the edge that samples operand B, and it bypasses arbitration.
- R5: Consider an uncontended valid request whose command is sampled at edge N. Its response is visible after edge N+2+LAT, where LAT is the pipe latency (default 2).
- R6: At most one add/subtract and at most one shift are in execution at any time. Each operation occupies its pipe for LAT+1 cycles. An add/subtract and a shift can execute in parallel.
- R7: Within one pipe class, a request that became ready earlier is granted before a later one, whatever the port indices.
- R8: Requests that become ready in the same cycle are served one after another, each exactly once, in the order set by a rotating pointer.
- R9: A synchronous active-high reset clears all outputs and drops every pending and executing request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | NPORT*4 | Per-port command code |
| data_i | input | NPORT*32 | Per-port operand input (A with the command, B the cycle after) |
| resp_o | output | NPORT*2 | Per-port status: 0 none, 1 ok, 2 error, 3 reserved |
| data_o | output | NPORT*32 | Per-port result, valid with a nonzero status |

## Verification
The bound checker watches four things on every cycle: status and data stay silent together, a response lasts exactly one cycle, error responses carry zero data, and the reserved status code never appears. On the pipe side it checks that grants are one-hot and that a pipe is granted only when idle, which covers the one-operation-per-pipe rule. The remaining behaviour is shown only by the bench's scenarios. That covers arithmetic correctness, overflow and underflow detection, the end-to-end latency, the arrival-order grant when a pointer would choose otherwise, the serial spacing of simultaneous requests, and the dropping of work on reset. A sweep of every port against every command code over boundary operand pairs exercises these.

// File: rtl/qcalc_pkg.sv
package qcalc_pkg;

    localparam int DW    = 32;
    localparam int CW    = 4;
    localparam int SHW   = $clog2(DW);
    localparam int NPIPE = 2;          // 0: add/subtract, 1: shifts

    typedef logic [CW-1:0] cmd_t;

    localparam cmd_t CMD_IDLE = 4'd0;
    localparam cmd_t CMD_ADD  = 4'd1;
    localparam cmd_t CMD_SUB  = 4'd2;
    localparam cmd_t CMD_SHL  = 4'd5;
    localparam cmd_t CMD_SHR  = 4'd6;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_OK    = 2'd1,
        RSP_ERR   = 2'd2,
        RSP_FAULT = 2'd3
    } rsp_e;

    typedef struct packed {
        cmd_t          op;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } req_t;

    typedef struct packed {
        rsp_e          rsp;
        logic [DW-1:0] data;
    } res_t;

    function automatic logic cmd_known(cmd_t c);
        return (c == CMD_ADD) || (c == CMD_SUB) || (c == CMD_SHL) || (c == CMD_SHR);
    endfunction

    function automatic logic cmd_is_shift(cmd_t c);
        return (c == CMD_SHL) || (c == CMD_SHR);
    endfunction

    function automatic res_t evaluate(req_t r);
        res_t          o;
        logic [DW:0]   sum;
        logic [SHW-1:0] amt;
        sum = {1'b0, r.a} + {1'b0, r.b};
        amt = r.b[SHW-1:0];
        o.rsp  = RSP_OK;
        o.data = '0;
        case (r.op)
            CMD_ADD: if (sum[DW]) o.rsp = RSP_ERR; else o.data = sum[DW-1:0];
            CMD_SUB: if (r.b > r.a) o.rsp = RSP_ERR; else o.data = r.a - r.b;
            CMD_SHL: o.data = r.a << amt;
            CMD_SHR: o.data = r.a >> amt;
            default: o.rsp = RSP_ERR;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/qcalc_port.sv
module qcalc_port
    import qcalc_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_t          cmd_i,
    input  logic [DW-1:0] din_i,
    input  logic          grant_i,
    input  logic          done_i,
    output logic          ready_o,
    output logic          shift_o,
    output logic          bad_o,
    output req_t          req_o,
    output logic [AW-1:0] age_o
);

    typedef enum logic [1:0] {S_IDLE, S_OP2, S_WAIT, S_BUSY} st_e;

    st_e           st;
    req_t          req;
    logic [AW-1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            req <= '0;
            age <= '0;
        end else begin
            case (st)
                S_IDLE: if (cmd_i != CMD_IDLE) begin
                    req.op <= cmd_i;
                    req.a  <= din_i;
                    st     <= S_OP2;
                end
                S_OP2: begin
                    req.b <= din_i;
                    age   <= '0;
                    st    <= cmd_known(req.op) ? S_WAIT : S_IDLE;
                end
                S_WAIT: begin
                    if (grant_i)        st  <= S_BUSY;
                    else if (age != '1) age <= age + 1'b1;
                end
                S_BUSY: if (done_i) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign ready_o = (st == S_WAIT);
    assign shift_o = cmd_is_shift(req.op);
    assign bad_o   = (st == S_OP2) && !cmd_known(req.op);
    assign req_o   = req;
    assign age_o   = age;

endmodule

// File: rtl/qcalc_arb.sv
module qcalc_arb #(
    parameter int NPORT = 4,
    parameter int AW    = 4,
    parameter int PW    = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPORT-1:0]          req_i,
    input  logic [NPORT-1:0][AW-1:0]  age_i,
    input  logic                      free_i,
    output logic [NPORT-1:0]          gnt_o,
    output logic [PW-1:0]             idx_o,
    output logic                      any_o
);

    logic [PW-1:0] ptr;
    logic [AW-1:0] oldest;

    always_comb begin
        oldest = '0;
        for (int i = 0; i < NPORT; i++)
            if (req_i[i] && age_i[i] > oldest) oldest = age_i[i];
        gnt_o = '0;
        idx_o = '0;
        any_o = 1'b0;
        for (int k = 0; k < NPORT; k++) begin
            int j;
            j = int'(ptr) + k;
            if (j >= NPORT) j = j - NPORT;
            if (!any_o && free_i && req_i[j] && age_i[j] == oldest) begin
                any_o    = 1'b1;
                gnt_o[j] = 1'b1;
                idx_o    = PW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        ptr <= '0;
        else if (any_o) ptr <= (int'(idx_o) == NPORT - 1) ? '0 : idx_o + 1'b1;
    end

endmodule

// File: rtl/qcalc_pipe.sv
module qcalc_pipe
    import qcalc_pkg::*;
#(
    parameter int LAT = 2,
    parameter int PW  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  req_t          req_i,
    input  logic [PW-1:0] owner_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [PW-1:0] owner_o,
    output res_t          res_o
);

    localparam int TW = (LAT > 1) ? $clog2(LAT) : 1;

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o  <= 1'b0;
            cnt     <= '0;
            owner_o <= '0;
            res_o   <= '0;
        end else if (load_i) begin
            busy_o  <= 1'b1;
            cnt     <= TW'(LAT - 1);
            owner_o <= owner_i;
            res_o   <= evaluate(req_i);
        end else if (busy_o) begin
            if (cnt == '0) busy_o <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign done_o = busy_o && (cnt == '0);

endmodule

// File: rtl/quad_port_calc.sv
module quad_port_calc
    import qcalc_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int LAT   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORT-1:0][CW-1:0] cmd_i,
    input  logic [NPORT-1:0][DW-1:0] data_i,
    output logic [NPORT-1:0][1:0]    resp_o,
    output logic [NPORT-1:0][DW-1:0] data_o
);

    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam int AW = $clog2(NPORT * (LAT + 1) + 2);

    logic [NPORT-1:0]          ready, shift, bad, grant, done;
    logic [NPORT-1:0][AW-1:0]  age;
    req_t                      reqs [NPORT];

    logic [NPIPE-1:0][NPORT-1:0] pgnt;
    logic [NPIPE-1:0][PW-1:0]    pidx, powner;
    logic [NPIPE-1:0]            pany, pbusy, pdone;
    res_t                        pres [NPIPE];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        qcalc_port #(.AW(AW)) u_port (
            .clk    (clk),
            .rst    (rst),
            .cmd_i  (cmd_i[p]),
            .din_i  (data_i[p]),
            .grant_i(grant[p]),
            .done_i (done[p]),
            .ready_o(ready[p]),
            .shift_o(shift[p]),
            .bad_o  (bad[p]),
            .req_o  (reqs[p]),
            .age_o  (age[p])
        );
    end

    for (genvar k = 0; k < NPIPE; k++) begin : g_pipe
        logic [NPORT-1:0] class_req;
        assign class_req = ready & ((k == 1) ? shift : ~shift);

        qcalc_arb #(.NPORT(NPORT), .AW(AW), .PW(PW)) u_arb (
            .clk   (clk),
            .rst   (rst),
            .req_i (class_req),
            .age_i (age),
            .free_i(!pbusy[k]),
            .gnt_o (pgnt[k]),
            .idx_o (pidx[k]),
            .any_o (pany[k])
        );

        qcalc_pipe #(.LAT(LAT), .PW(PW)) u_pipe (
            .clk    (clk),
            .rst    (rst),
            .load_i (pany[k]),
            .req_i  (reqs[pidx[k]]),
            .owner_i(pidx[k]),
            .busy_o (pbusy[k]),
            .done_o (pdone[k]),
            .owner_o(powner[k]),
            .res_o  (pres[k])
        );
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            grant[p] = 1'b0;
            done[p]  = 1'b0;
            for (int k = 0; k < NPIPE; k++) begin
                grant[p] = grant[p] | pgnt[k][p];
                done[p]  = done[p] | (pdone[k] && powner[k] == PW'(p));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_o <= '0;
            data_o <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                resp_o[p] <= RSP_NONE;
                data_o[p] <= '0;
                if (bad[p]) resp_o[p] <= RSP_ERR;
                for (int k = 0; k < NPIPE; k++) begin
                    if (pdone[k] && powner[k] == PW'(p)) begin
                        resp_o[p] <= pres[k].rsp;
                        data_o[p] <= pres[k].data;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/quad_port_calc_chk.sv
module quad_port_calc_chk
    import qcalc_pkg::*;
#(
    parameter int NPORT = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NPORT-1:0][1:0]       resp,
    input logic [NPORT-1:0][DW-1:0]    data,
    input logic [NPIPE-1:0][NPORT-1:0] gnt,
    input logic [NPIPE-1:0]            busy
);

    for (genvar p = 0; p < NPORT; p++) begin : g_p
        assert_quiet_zero_R2: assert property (@(posedge clk) disable iff (rst)
            (resp[p] == 2'd0) |-> (data[p] == '0));
        assert_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
            (resp[p] != 2'd0) |=> (resp[p] == 2'd0));
        assert_no_fault_R2: assert property (@(posedge clk) disable iff (rst)
            resp[p] != 2'd3);
        assert_err_data_R3: assert property (@(posedge clk) disable iff (rst)
            (resp[p] == 2'd2) |-> (data[p] == '0));
        assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (resp[p] == 2'd0 && data[p] == '0));
    end

    for (genvar k = 0; k < NPIPE; k++) begin : g_k
        assert_single_grant_R6: assert property (@(posedge clk) disable iff (rst)
            $onehot0(gnt[k]));
        assert_idle_pipe_R6: assert property (@(posedge clk) disable iff (rst)
            (gnt[k] != '0) |-> !busy[k]);
    end

endmodule

bind quad_port_calc quad_port_calc_chk #(.NPORT(NPORT)) u_chk (
    .clk (clk),
    .rst (rst),
    .resp(resp_o),
    .data(data_o),
    .gnt (pgnt),
    .busy(pbusy)
);

// File: tb/quad_port_calc_bench.sv
`timescale 1ns/1ps
module quad_port_calc_bench;

    localparam int NP = 4;
    localparam int L  = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NP-1:0][3:0]  cmd = '0;
    logic [NP-1:0][31:0] din = '0;
    logic [NP-1:0][1:0]  resp;
    logic [NP-1:0][31:0] dout;

    quad_port_calc #(.NPORT(NP), .LAT(L)) u_quad_port_calc (
        .clk(clk), .rst(rst), .cmd_i(cmd), .data_i(din), .resp_o(resp), .data_o(dout)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0, cyc = 0, noisy = 0;
    int rcnt [NP];
    int rcyc [NP];
    logic [1:0]  rrsp [NP];
    logic [31:0] rdat [NP];
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (resp[p] != 2'd0) begin
                rcnt[p]++; rcyc[p] = cyc; rrsp[p] = resp[p]; rdat[p] = dout[p];
            end else if (dout[p] != 32'd0) noisy++;
        end
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [33:0] model(logic [3:0] c, logic [31:0] a, logic [31:0] b);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b};
        case (c)
            4'd1: model = s[32] ? {2'd2, 32'd0} : {2'd1, s[31:0]};
            4'd2: model = (b > a) ? {2'd2, 32'd0} : {2'd1, a - b};
            4'd5: model = {2'd1, a << b[4:0]};
            4'd6: model = {2'd1, a >> b[4:0]};
            default: model = {2'd2, 32'd0};
        endcase
    endfunction

    function automatic bit known(logic [3:0] c);
        return c == 4'd1 || c == 4'd2 || c == 4'd5 || c == 4'd6;
    endfunction

    task automatic issue(int p, logic [3:0] c, logic [31:0] a, logic [31:0] b, output int t0);
        @(negedge clk); cmd[p] = c; din[p] = a; t0 = cyc + 1;
        @(negedge clk); cmd[p] = 4'd0; din[p] = b;
        @(negedge clk); din[p] = 32'd0;
    endtask

    task automatic clear_mon();
        for (int p = 0; p < NP; p++) rcnt[p] = 0;
    endtask

    task automatic run_one(int p, logic [3:0] c, logic [31:0] a, logic [31:0] b);
        int t0;
        logic [33:0] e;
        clear_mon();
        issue(p, c, a, b, t0);
        repeat (6) @(negedge clk);
        e = model(c, a, b);
        chk(rcnt[p] == 1, known(c) ? "R2 single response" : "R4 single response", rcnt[p], 1);
        chk(rrsp[p] == e[33:32], !known(c) ? "R4 status" : (e[33:32] == 2'd2 ? "R3 status" : "R1 status"),
            rrsp[p], e[33:32]);
        chk(rdat[p] == e[31:0], known(c) ? "R1 data" : "R4 data", rdat[p], e[31:0]);
        chk(rcyc[p] - t0 == (known(c) ? L + 2 : 1), known(c) ? "R5 latency" : "R4 latency",
            rcyc[p] - t0, known(c) ? L + 2 : 1);
    endtask

    logic [31:0] va [7] = '{32'd5, 32'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h8000_0000, 32'h1234_5678, 32'hA5A5_A5A5};
    logic [31:0] vb [7] = '{32'd3, 32'd5, 32'd1,          32'd1,          32'h8000_0000, 32'h0000_0025, 32'h0000_001F};

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t [NP];
        bit [15:0] seen;
        clear_mon();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int p = 0; p < NP; p++) chk(resp[p] == 2'd0 && dout[p] == 32'd0, "R9 reset outputs", resp[p], 0);

        // sweep: every port, every command code, boundary operands
        for (int p = 0; p < NP; p++)
            for (int c = 1; c < 16; c++)
                for (int v = 0; v < 7; v++)
                    run_one(p, 4'(c), va[v], vb[v]);

        // R8: four simultaneous adds serialise with spacing LAT+1
        for (int round = 0; round < 2; round++) begin
            clear_mon(); seen = '0;
            fork
                issue(0, 4'd1, 32'd10, 32'd1, t[0]);
                issue(1, 4'd1, 32'd20, 32'd2, t[1]);
                issue(2, 4'd1, 32'd30, 32'd3, t[2]);
                issue(3, 4'd1, 32'd40, 32'd4, t[3]);
            join
            repeat (16) @(negedge clk);
            for (int p = 0; p < NP; p++) begin
                int lat;
                lat = rcyc[p] - t[p];
                chk(rcnt[p] == 1 && rdat[p] == 32'(11 * (p + 1)), "R8 tie served once", rdat[p], 11 * (p + 1));
                chk((lat - (L + 2)) % (L + 1) == 0 && lat >= L + 2 && lat <= L + 2 + 3 * (L + 1) && !seen[lat],
                    "R8 tie slot", lat, L + 2);
                if (lat >= 0 && lat < 16) seen[lat] = 1'b1;
            end
        end

        // R6: add and shift execute in parallel; two shifts serialise
        clear_mon();
        fork
            issue(0, 4'd1, 32'd7, 32'd8, t[0]);
            issue(1, 4'd5, 32'd3, 32'd4, t[1]);
            issue(2, 4'd6, 32'h100, 32'd4, t[2]);
        join
        repeat (12) @(negedge clk);
        chk(rcyc[0] - t[0] == L + 2 && rdat[0] == 32'd15, "R6 add beside shift", rcyc[0] - t[0], L + 2);
        chk((rcyc[1] - t[1]) + (rcyc[2] - t[2]) == 2 * (L + 2) + L + 1, "R6 shifts serialised",
            (rcyc[1] - t[1]) + (rcyc[2] - t[2]), 2 * (L + 2) + L + 1);
        chk(rdat[1] == 32'd48 && rdat[2] == 32'h10, "R6 shift data", rdat[1], 48);

        // R7: arrival order beats the rotating pointer (pointer would favour port 2)
        clear_mon();
        fork
            issue(1, 4'd1, 32'd1, 32'd1, t[1]);
            begin @(negedge clk); issue(0, 4'd2, 32'd9, 32'd4, t[0]); end
            begin repeat (2) @(negedge clk); issue(2, 4'd1, 32'd6, 32'd6, t[2]); end
        join
        repeat (14) @(negedge clk);
        chk(rcyc[1] - t[1] == L + 2, "R7 first arrival", rcyc[1] - t[1], L + 2);
        chk(rcyc[0] - t[0] == 2 * L + 2, "R7 second arrival", rcyc[0] - t[0], 2 * L + 2);
        chk(rcyc[2] - t[2] == 3 * L + 2, "R7 third arrival", rcyc[2] - t[2], 3 * L + 2);
        chk(rdat[0] == 32'd5 && rdat[2] == 32'd12, "R7 data", rdat[0], 5);

        // R9: reset mid-flight drops the pending request
        clear_mon();
        issue(3, 4'd1, 32'd2, 32'd2, t[3]);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(rcnt[3] == 0, "R9 pending dropped", rcnt[3], 0);
        run_one(3, 4'd2, 32'd9, 32'd2);

        chk(noisy == 0, "R2 data zero when silent", noisy, 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule